// File: doc/BRIEF.md
# Inverse-Butterfly Shift and Field Unit

This block is a 64-bit shifter for an integer execution pipe. It does not use a log shifter. The data moves through an inverse-butterfly network of pass/swap switches. There are log2(W) stages, and stage k pairs bits that are 2^k positions apart (k counted from 0). The switch settings are computed from a single rotate amount. The network always performs a right rotation, and a left rotation by s is realised as a right rotation by (W − s) mod W.

Shifts, field extracts and field deposits are all a rotation followed by one masking stage. That stage zeroes the bits outside the kept range, fills them with a replicated sign bit, or takes them from a second operand. The result is captured in an output register, so every operation has a latency of exactly one clock.

Top module: `ibsr_shift_unit`

## Requirements
- R1: While `rst_n` is low the result register clears, and `res_o` reads zero after reset.
- R2: The result for the inputs present at a rising clock edge appears on `res_o` after that edge and holds until the next edge.
- R3: `op_i`=0 rotates `src_a_i` left by `amt_i`. `op_i`=1 rotates it right by `amt_i`.
- R4: `op_i`=2 shifts `src_a_i` left by `amt_i` and fills the vacated low bits with zeros.
- R5: `op_i`=3 shifts right with zero fill. `op_i`=4 shifts right and fills the vacated high bits with bit 63 of `src_a_i`.
- R6: `op_i`=5 takes the `len_i`-bit field of `src_a_i` whose lowest bit is at position `amt_i`, right-justifies it, and zeroes all higher bits.
- R7: `op_i`=6 works like code 5, except that all bits above the field are copies of the field's top bit.
- R8: `op_i`=7 places the low `len_i` bits of `src_a_i` at position `amt_i`. The bits outside the field are zero when `merge_i`=0 and come from `src_b_i` when `merge_i`=1.
- R9: When `amt_i`+`len_i` exceeds 64, including any `len_i` above 64, the field is cut at bit 63. Its effective length is then 64 − `amt_i`.
- R10: A `len_i` of 0 gives zero for codes 5 and 6 and for code 7 with `merge_i`=0. It returns `src_b_i` unchanged for code 7 with `merge_i`=1.
- R11: An amount of 0 returns `src_a_i` unchanged for codes 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation code (0 rotl, 1 rotr, 2 shl, 3 shr, 4 sar, 5 extract unsigned, 6 extract signed, 7 deposit) |
| merge_i | input | 1 | Deposit only: 1 keeps `src_b_i` outside the field, 0 zeroes it |
| amt_i | input | 6 | Shift or rotate amount, or the field's lowest bit position |
| len_i | input | 7 | Field length in bits (0 to 127, clipped per R9) |
| src_a_i | input | 64 | Data operand |
| src_b_i | input | 64 | Merge operand for deposit |
| res_o | output | 64 | Registered result |

## Verification
The checker compares every rotate, logical shift and arithmetic shift against a plain shift-operator formula on every cycle. It also checks the zero-length cases of extract and deposit, which covers R3, R4, R5 and R10 independently of the switch network. Field extraction with sign fill, deposit merging at arbitrary positions, and truncation at bit 63 depend on length and position combinations. These are shown by the bench's bit-by-bit reference model over amount sweeps, directed corners and random vectors.

// File: rtl/ibsr_pkg.sv
`timescale 1ns/1ps
package ibsr_pkg;
    typedef enum logic [2:0] {
        OP_ROTL = 3'd0,
        OP_ROTR = 3'd1,
        OP_SHL  = 3'd2,
        OP_SHR  = 3'd3,
        OP_SAR  = 3'd4,
        OP_EXTU = 3'd5,
        OP_EXTS = 3'd6,
        OP_DEP  = 3'd7
    } shop_e;
endpackage

// File: rtl/ibsr_ctrl_gen.sv
`timescale 1ns/1ps
// Switch controls for a right rotation by rot_amt on an inverse butterfly.
// Stage k works on spans of 2H bits (H = 2^k). Each half of a span has
// already been rotated by rot_amt mod H. Switch j swaps when its source
// crossed the half boundary, inverted by bit k of the amount.
module ibsr_ctrl_gen #(
    parameter int W   = 64,
    parameter int LGW = $clog2(W)
) (
    input  logic [LGW-1:0]             rot_amt,
    output logic [LGW-1:0][W/2-1:0]    ctrl
);
    for (genvar k = 0; k < LGW; k++) begin : g_stage
        localparam int H = 1 << k;
        logic [LGW:0] low_part;
        assign low_part = {1'b0, rot_amt & LGW'(H - 1)};
        for (genvar p = 0; p < W/2; p++) begin : g_sw
            localparam int J = p % H;
            assign ctrl[k][p] = (((LGW+1)'(J) + low_part) >= (LGW+1)'(H)) ^ rot_amt[k];
        end
    end
endmodule

// File: rtl/ibsr_ibfly_net.sv
`timescale 1ns/1ps
// Inverse-butterfly network: stage k pairs bits H = 2^k apart.
module ibsr_ibfly_net #(
    parameter int W   = 64,
    parameter int LGW = $clog2(W)
) (
    input  logic [W-1:0]               din,
    input  logic [LGW-1:0][W/2-1:0]    ctrl,
    output logic [W-1:0]               dout
);
    logic [LGW:0][W-1:0] lvl;
    assign lvl[0] = din;

    for (genvar k = 0; k < LGW; k++) begin : g_stage
        localparam int H = 1 << k;
        for (genvar p = 0; p < W/2; p++) begin : g_sw
            localparam int LO = (p / H) * 2 * H + (p % H);
            localparam int HI = LO + H;
            assign lvl[k+1][LO] = ctrl[k][p] ? lvl[k][HI] : lvl[k][LO];
            assign lvl[k+1][HI] = ctrl[k][p] ? lvl[k][LO] : lvl[k][HI];
        end
    end

    assign dout = lvl[LGW];
endmodule

// File: rtl/ibsr_mask_stage.sv
`timescale 1ns/1ps
// Masking, sign replication and merge applied to the rotated word.
module ibsr_mask_stage
    import ibsr_pkg::*;
#(
    parameter int W   = 64,
    parameter int LGW = $clog2(W)
) (
    input  shop_e          op,
    input  logic           merge,
    input  logic [LGW-1:0] amt,
    input  logic [LGW:0]   len,
    input  logic [W-1:0]   rot,
    input  logic [W-1:0]   src_a,
    input  logic [W-1:0]   src_b,
    output logic [W-1:0]   res
);
    function automatic logic [W-1:0] low_ones(input logic [LGW:0] n);
        if (n >= (LGW+1)'(W)) return '1;
        return (W'(1) << n) - W'(1);
    endfunction

    logic [LGW:0]  room;      // W - amt, 1..W
    logic [LGW:0]  fld_len;   // field length cut at the top bit (R9)
    logic [W-1:0]  keep_lo;   // low ones for right shifts
    logic [W-1:0]  fld_lo;    // low ones for the field
    logic          fld_sign;

    always_comb begin
        room     = (LGW+1)'(W) - {1'b0, amt};
        fld_len  = (len > room) ? room : len;
        keep_lo  = low_ones(room);
        fld_lo   = low_ones(fld_len);
        fld_sign = (fld_len == '0) ? 1'b0 : rot[LGW'(fld_len - 1'b1)];
        unique case (op)
            OP_ROTL, OP_ROTR: res = rot;                                         // R3
            OP_SHL:  res = rot & ~low_ones({1'b0, amt});                         // R4
            OP_SHR:  res = rot & keep_lo;                                        // R5
            OP_SAR:  res = (rot & keep_lo) | (src_a[W-1] ? ~keep_lo : '0);       // R5
            OP_EXTU: res = rot & fld_lo;                                         // R6
            OP_EXTS: res = (rot & fld_lo) | (fld_sign ? ~fld_lo : '0);           // R7
            OP_DEP:  res = (rot & (fld_lo << amt))
                         | (merge ? (src_b & ~(fld_lo << amt)) : '0);            // R8
            default: res = rot;
        endcase
    end
endmodule

// File: rtl/ibsr_shift_unit.sv
`timescale 1ns/1ps
module ibsr_shift_unit
    import ibsr_pkg::*;
#(
    parameter int W   = 64,
    parameter int LGW = $clog2(W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      op_i,
    input  logic            merge_i,
    input  logic [LGW-1:0]  amt_i,
    input  logic [LGW:0]    len_i,
    input  logic [W-1:0]    src_a_i,
    input  logic [W-1:0]    src_b_i,
    output logic [W-1:0]    res_o
);
    typedef struct packed {
        logic [W-1:0] res;
    } state_t;

    state_t state_d, state_q;

    shop_e                       op;
    logic                        rot_left;
    logic [LGW-1:0]              rot_amt;
    logic [LGW-1:0][W/2-1:0]     ctrl;
    logic [W-1:0]                rotated;
    logic [W-1:0]                masked;

    assign op       = shop_e'(op_i);
    // Left-moving ops become a right rotation by (W - amt) mod W.
    assign rot_left = (op == OP_ROTL) || (op == OP_SHL) || (op == OP_DEP);
    assign rot_amt  = rot_left ? (LGW'(0) - amt_i) : amt_i;

    ibsr_ctrl_gen #(.W(W), .LGW(LGW)) u_ctrl (
        .rot_amt (rot_amt),
        .ctrl    (ctrl)
    );

    ibsr_ibfly_net #(.W(W), .LGW(LGW)) u_net (
        .din  (src_a_i),
        .ctrl (ctrl),
        .dout (rotated)
    );

    ibsr_mask_stage #(.W(W), .LGW(LGW)) u_mask (
        .op    (op),
        .merge (merge_i),
        .amt   (amt_i),
        .len   (len_i),
        .rot   (rotated),
        .src_a (src_a_i),
        .src_b (src_b_i),
        .res   (masked)
    );

    always_comb begin
        state_d     = state_q;
        state_d.res = masked;   // R2: one register between inputs and result
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;   // R1
        else        state_q <= state_d;
    end

    assign res_o = state_q.res;
endmodule

// File: rtl/ibsr_shift_unit_chk.sv
`timescale 1ns/1ps
module ibsr_shift_unit_chk #(
    parameter int W   = 64,
    parameter int LGW = $clog2(W)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [2:0]      op_i,
    input logic            merge_i,
    input logic [LGW-1:0]  amt_i,
    input logic [LGW:0]    len_i,
    input logic [W-1:0]    src_a_i,
    input logic [W-1:0]    src_b_i,
    input logic [W-1:0]    res_o
);
    a_r3_rotl: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd0) |=> res_o == (($past(src_a_i) << $past(amt_i))
                                   | ($past(src_a_i) >> (W - int'($past(amt_i))))));

    a_r3_rotr: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd1) |=> res_o == (($past(src_a_i) >> $past(amt_i))
                                   | ($past(src_a_i) << (W - int'($past(amt_i))))));

    a_r4_shl: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd2) |=> res_o == ($past(src_a_i) << $past(amt_i)));

    a_r5_shr: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd3) |=> res_o == ($past(src_a_i) >> $past(amt_i)));

    a_r5_sar: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd4) |=> res_o == W'($signed($past(src_a_i)) >>> $past(amt_i)));

    a_r10_ext_len0: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == 3'd5 || op_i == 3'd6) && len_i == '0) |=> res_o == '0);

    a_r10_dep_len0: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd7 && len_i == '0) |=> res_o == ($past(merge_i) ? $past(src_b_i) : '0));
endmodule

bind ibsr_shift_unit ibsr_shift_unit_chk #(.W(W), .LGW(LGW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_i),
    .merge_i (merge_i),
    .amt_i   (amt_i),
    .len_i   (len_i),
    .src_a_i (src_a_i),
    .src_b_i (src_b_i),
    .res_o   (res_o)
);

// File: tb/ibsr_shift_unit_bench.sv
`timescale 1ns/1ps
module ibsr_shift_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic        merge_i = 1'b0;
    logic [5:0]  amt_i = 6'd0;
    logic [6:0]  len_i = 7'd0;
    logic [63:0] src_a_i = '0;
    logic [63:0] src_b_i = '0;
    logic [63:0] res_o;

    int nvec = 0;
    int nerr = 0;
    bit done = 0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    ibsr_shift_unit u_ibsr_shift_unit (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .merge_i(merge_i),
        .amt_i(amt_i), .len_i(len_i), .src_a_i(src_a_i), .src_b_i(src_b_i),
        .res_o(res_o)
    );

    function automatic logic [63:0] model(input int op, input logic [63:0] a,
                                          input logic [63:0] b, input int amt,
                                          input int len, input bit merge);
        logic [63:0] y = '0;
        int le = (len > 64 - amt) ? 64 - amt : len;
        for (int i = 0; i < 64; i++) begin
            case (op)
                0: y[(i + amt) % 64] = a[i];
                1: y[i] = a[(i + amt) % 64];
                2: y[i] = (i >= amt) ? a[i - amt] : 1'b0;
                3: y[i] = (i + amt < 64) ? a[i + amt] : 1'b0;
                4: y[i] = (i + amt < 64) ? a[i + amt] : a[63];
                5: y[i] = (i < le) ? a[amt + i] : 1'b0;
                6: y[i] = (i < le) ? a[amt + i] : ((le > 0) ? a[amt + le - 1] : 1'b0);
                default: y[i] = (i >= amt && i < amt + le) ? a[i - amt] : (merge ? b[i] : 1'b0);
            endcase
        end
        return y;
    endfunction

    task automatic compare_pending();
        if (exp_q.size() > 0) begin
            logic [63:0] e = exp_q.pop_front();
            string t = tag_q.pop_front();
            nvec++;
            if (res_o !== e) begin
                nerr++;
                $display("FAIL %s: res_o=%h expected=%h", t, res_o, e);
            end
        end
    endtask

    task automatic apply(input int op, input logic [63:0] a, input logic [63:0] b,
                         input int amt, input int len, input bit merge, input string tag);
        @(negedge clk);
        compare_pending();
        op_i = 3'(op); src_a_i = a; src_b_i = b; amt_i = 6'(amt);
        len_i = 7'(len); merge_i = merge;
        exp_q.push_back(model(op, a, b, amt, len, merge));
        tag_q.push_back(tag);
    endtask

    string op_tag[8] = '{"R3", "R3", "R4", "R5", "R5", "R6", "R7", "R8"};

    initial begin
        repeat (3) @(negedge clk);
        nvec++;
        if (res_o !== 64'h0) begin
            nerr++;
            $display("FAIL R1: res_o=%h expected=%h after reset", res_o, 64'h0);
        end
        rst_n = 1'b1;

        // R11: zero amount is identity for rotates and shifts
        for (int op = 0; op < 5; op++)
            apply(op, 64'hF0E1_D2C3_B4A5_9687, '0, 0, 0, 0, "R11");
        // R3 rotates
        apply(0, 64'h8000_0000_0000_0001, '0, 1, 0, 0, "R3");
        apply(1, 64'h8000_0000_0000_0001, '0, 63, 0, 0, "R3");
        // R4 / R5 shifts
        apply(2, 64'hFFFF_FFFF_FFFF_FFFF, '0, 63, 0, 0, "R4");
        apply(3, 64'h8000_0000_0000_0000, '0, 63, 0, 0, "R5");
        apply(4, 64'h8000_0000_0000_0000, '0, 63, 0, 0, "R5");
        apply(4, 64'h7FFF_0000_0000_0000, '0, 8, 0, 0, "R5");
        // R6 / R7 extracts
        apply(5, 64'h0000_0000_00AB_CD00, '0, 8, 16, 0, "R6");
        apply(6, 64'h0000_0000_008B_CD00, '0, 8, 16, 0, "R7");
        apply(6, 64'h0000_0000_007B_CD00, '0, 8, 16, 0, "R7");
        // R8 deposits
        apply(7, 64'h0000_0000_0000_00FF, 64'h5555_5555_5555_5555, 20, 8, 0, "R8");
        apply(7, 64'h0000_0000_0000_00FF, 64'h5555_5555_5555_5555, 20, 8, 1, "R8");
        // R9 truncation at bit 63
        apply(5, 64'hF000_0000_0000_0000, '0, 60, 10, 0, "R9");
        apply(6, 64'hF000_0000_0000_0000, '0, 60, 10, 0, "R9");
        apply(7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, 60, 10, 1, "R9");
        apply(5, 64'hDEAD_BEEF_CAFE_F00D, '0, 0, 100, 0, "R9");
        apply(7, 64'hDEAD_BEEF_CAFE_F00D, '0, 4, 127, 0, "R9");
        // R10 zero length
        apply(5, 64'hFFFF_FFFF_FFFF_FFFF, '0, 12, 0, 0, "R10");
        apply(6, 64'hFFFF_FFFF_FFFF_FFFF, '0, 12, 0, 0, "R10");
        apply(7, 64'hFFFF_FFFF_FFFF_FFFF, 64'hA5A5_5A5A_0F0F_F0F0, 12, 0, 1, "R10");
        apply(7, 64'hFFFF_FFFF_FFFF_FFFF, 64'hA5A5_5A5A_0F0F_F0F0, 12, 0, 0, "R10");

        // Amount sweep over every op
        for (int op = 0; op < 8; op++)
            for (int s = 0; s < 64; s++)
                apply(op, {$urandom(), $urandom()}, {$urandom(), $urandom()},
                      s, int'($urandom_range(0, 70)), 1'($urandom()), op_tag[op]);

        // Random vectors; R2 holds on every cycle since each result is checked one clock later
        for (int n = 0; n < 3000; n++) begin
            int op = int'($urandom_range(0, 7));
            apply(op, {$urandom(), $urandom()}, {$urandom(), $urandom()},
                  int'($urandom_range(0, 63)), int'($urandom_range(0, 127)),
                  1'($urandom()), (n % 2 == 0) ? "R2" : op_tag[op]);
        end

        @(negedge clk);
        compare_pending();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end
endmodule